// File: doc/BRIEF.md
# Frame Buffer Sequence Manager

This block decides which slot of an external image memory each arriving frame goes into and which slot is sent out next. It holds only slot indices, an occupancy count, a count of pending read requests and a small phase state; the pixel data, the memory controller and any address arithmetic inside a frame belong to other blocks. A frame-arrived strobe, a read request (CC2 or the equivalent serial command) and a clear request (CC3 or its serial equivalent) drive it. It answers with a write-enable and write slot, a read-start pulse and read slot, and three status flags.

Two behaviours share one pointer engine. In queue mode, frames are kept until every slot is used and later frames are dropped. Each read request sends out the oldest stored frame and frees its slot. A request made while nothing is stored is held, and the next frame to arrive is read out as it is written. In ring mode, the memory keeps recording and overwrites the oldest slot. The first read request is a trigger: a programmed number of further frames is recorded, and then recording stops. Read requests given after the trigger are queued and served oldest first once recording has stopped. Only a clear request re-arms the trigger. The mode, the slot count and the post-trigger count are static and are changed only together with a clear.

Top module: `fbuf_seq_mgr`

## Requirements
- R1: While reset is low and in the first cycle after it, empty is 1, full and stopped are 0, and wr_en and rd_start are 0.
- R2: In queue mode (circ_mode=0), a frame_in accepted at a clock edge gives wr_en=1 in the following cycle, with wr_slot counting 0,1,2,... and wrapping to 0 after slot_count-1.
- R3: In queue mode, a frame_in that arrives while full=1 is dropped: no wr_en follows and the slot order is unchanged.
- R4: In queue mode, a read request while frames are stored gives rd_start=1 in the following cycle, with rd_slot the oldest stored slot, and frees that slot. At most one read starts per cycle.
- R5: In queue mode, read requests made while empty are held. The next frame then gives wr_en and rd_start in the same cycle, both with the same slot.
- R6: A clr_req empties the buffer, returns both slot pointers to 0, drops pending requests and returns to the armed phase. In the clearing cycle it takes precedence over frame_in and rd_req, so no wr_en or rd_start follows it.
- R7: In ring mode (circ_mode=1) before the trigger, every frame is written. When the buffer is full, the new frame overwrites the oldest slot and full stays 1. No rd_start is produced.
- R8: In ring mode, the first rd_req after a clear is a trigger and is not a read. After post_count further frames have been written, stopped becomes 1 and later frames are not written. With post_count=0, stopped becomes 1 right after the trigger.
- R9: In ring mode, read requests made after the trigger, including those given during the post-trigger window, are served one per cycle once stopped=1, oldest slot first, for as long as frames remain.
- R10: In ring mode, neither rd_req nor frame_in clears stopped; only clr_req does.
- R11: Pending read requests are counted up to 2^(SLOT_W+1)-1. Requests beyond that are lost, so at most that many frames are served from one burst of early requests.
- R12: empty is 1 exactly when no frame is stored, and full is 1 exactly when the number stored equals slot_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| circ_mode | input | 1 | 0 = queue mode, 1 = ring mode |
| slot_count | input | SLOT_W+1 | Number of slots in use, 1 to 2^SLOT_W |
| post_count | input | POST_W | Frames recorded after the ring-mode trigger |
| frame_in | input | 1 | One-cycle strobe: a frame has arrived |
| rd_req | input | 1 | One-cycle read request / ring trigger |
| clr_req | input | 1 | One-cycle clear request |
| wr_en | output | 1 | Store the arriving frame in wr_slot |
| wr_slot | output | SLOT_W | Slot the frame is written to |
| rd_start | output | 1 | One-cycle pulse: start sending rd_slot |
| rd_slot | output | SLOT_W | Slot to be read out |
| empty | output | 1 | No frame stored |
| full | output | 1 | All slot_count slots hold frames |
| stopped | output | 1 | Ring-mode recording has stopped |

## Verification
The bench goes after the pointer wrap at slot_count, a frame offered while full, and early requests on an empty queue. A design that dropped the early request would leave a frame stored instead of starting a read in the same cycle. A design that did not saturate the pending counter would wrap it and serve far fewer frames from a long burst of early requests. For ring mode it checks the slot order after overwrites, that the trigger itself is not served as a read, that requests given during the post-trigger window are served only after the stop and oldest first, and that the stop survives further requests and frames until a clear. A clear arriving together with a frame and a request must leave nothing behind: a design that let the frame through would write to a slot the bench does not expect.

// File: rtl/fbseq_pkg.sv
// Shared types for the frame buffer sequence manager.
// Assumes: nothing beyond the 1800-2017 language.
package fbseq_pkg;
    // Recording phase of ring mode; queue mode stays in PH_ARMED.
    typedef enum logic [1:0] {
        PH_ARMED = 2'd0,
        PH_DELAY = 2'd1,
        PH_STOP  = 2'd2
    } phase_t;
endpackage

// File: rtl/fbseq_ring_ptr.sv
// Slot pointer that steps through 0 .. slot_count-1 and wraps.
// Assumes: slot_count is between 1 and 2**SLOT_W and is changed only with clr.
module fbseq_ring_ptr #(
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [SLOT_W:0]   slot_count,
    output logic [SLOT_W-1:0] ptr
);
    localparam int CW = SLOT_W + 1;

    logic [SLOT_W-1:0] ptr_q;
    logic              at_last;

    // Detect the last slot in use.
    always_comb begin
        at_last = ({1'b0, ptr_q} == (slot_count - CW'(1)));
    end

    // Advance or wrap the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr_q <= '0;
        end else if (adv) begin
            ptr_q <= at_last ? '0 : ptr_q + SLOT_W'(1);
        end
    end

    assign ptr = ptr_q;

    // R2: the pointer never reaches slot_count.
    a_r2_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, ptr_q} < slot_count));
endmodule

// File: rtl/fbseq_pend_ctr.sv
// Saturating count of read requests not yet served.
// Assumes: dec is raised only when avail is 1; at most one inc and one dec per cycle.
module fbseq_pend_ctr #(
    parameter int CW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic avail
);
    localparam logic [CW-1:0] SAT_MAX = {CW{1'b1}};

    logic [CW-1:0] pend_q;

    // A request is available if one is stored or one arrives now.
    always_comb begin
        avail = (pend_q != '0) || inc;
    end

    // Count requests in, served requests out, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   if (pend_q != SAT_MAX) pend_q <= pend_q + CW'(1);
                2'b01:   pend_q <= pend_q - CW'(1);
                default: pend_q <= pend_q;
            endcase
        end
    end

    // R9: a read is started only against a request.
    a_r9_serve_has_request: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> ((pend_q != '0) || inc));
    // R11: the count holds at its top instead of wrapping.
    a_r11_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == SAT_MAX && inc && !dec && !clr) |=> (pend_q == SAT_MAX));
endmodule

// File: rtl/fbseq_phase_ctl.sv
// Ring-mode phase control: armed, post-trigger window, stopped.
// Assumes: in the window every frame_tick is a written frame; circ is static between clears.
module fbseq_phase_ctl #(
    parameter int POST_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                circ,
    input  logic                trig,
    input  logic                frame_tick,
    input  logic [POST_W-1:0]   post_count,
    output fbseq_pkg::phase_t   phase
);
    import fbseq_pkg::*;

    phase_t            phase_q;
    logic [POST_W-1:0] left_q;

    // Step through the phases and count post-trigger frames.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q <= PH_ARMED;
            left_q  <= '0;
        end else begin
            case (phase_q)
                PH_ARMED: if (circ && trig) begin
                    left_q  <= post_count;
                    phase_q <= (post_count == '0) ? PH_STOP : PH_DELAY;
                end
                PH_DELAY: if (frame_tick) begin
                    left_q <= left_q - POST_W'(1);
                    if (left_q == POST_W'(1)) phase_q <= PH_STOP;
                end
                default: phase_q <= phase_q;
            endcase
        end
    end

    assign phase = phase_q;

    // R10: only a clear leaves the stopped phase.
    a_r10_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STOP && !clr) |=> (phase_q == PH_STOP));
    // R8: the window counter is never zero while the window is open.
    a_r8_window_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DELAY) |-> (left_q != '0));
endmodule

// File: rtl/fbuf_seq_mgr.sv
// Frame buffer sequence manager: picks write and read slots of an external
// image memory in queue mode or ring mode, and keeps occupancy and flags.
// Assumes: frame_in, rd_req and clr_req are one-cycle pulses; a slot is free
// again once its read has started; mode and counts change only with a clear.
module fbuf_seq_mgr #(
    parameter int SLOT_W = 3,
    parameter int POST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              circ_mode,
    input  logic [SLOT_W:0]   slot_count,
    input  logic [POST_W-1:0] post_count,
    input  logic              frame_in,
    input  logic              rd_req,
    input  logic              clr_req,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic              rd_start,
    output logic [SLOT_W-1:0] rd_slot,
    output logic              empty,
    output logic              full,
    output logic              stopped
);
    import fbseq_pkg::*;

    localparam int CW = SLOT_W + 1;

    phase_t            phase;
    logic [CW-1:0]     occ_q;
    logic [SLOT_W-1:0] wr_ptr, rd_ptr;
    logic              is_full, is_empty;
    logic              accept, overwrite, serve, trig, pend_inc, avail;
    logic              wr_en_q, rd_start_q;
    logic [SLOT_W-1:0] wr_slot_q, rd_slot_q;

    // Occupancy flags.
    always_comb begin
        is_full  = (occ_q == slot_count);
        is_empty = (occ_q == '0);
    end

    // Per-cycle decisions for both modes; a clear suppresses them all.
    always_comb begin
        accept    = 1'b0;
        overwrite = 1'b0;
        serve     = 1'b0;
        trig      = 1'b0;
        pend_inc  = 1'b0;
        if (!clr_req) begin
            if (!circ_mode) begin
                accept   = frame_in && !is_full;
                pend_inc = rd_req;
                serve    = avail && (!is_empty || accept);
            end else begin
                trig     = rd_req && (phase == PH_ARMED);
                pend_inc = rd_req && (phase != PH_ARMED);
                if (phase != PH_STOP) begin
                    accept    = frame_in;
                    overwrite = frame_in && is_full;
                end else begin
                    serve = avail && !is_empty;
                end
            end
        end
    end

    fbseq_ring_ptr #(.SLOT_W(SLOT_W)) u_wr_ptr (
        .clk(clk), .rst_n(rst_n), .clr(clr_req), .adv(accept),
        .slot_count(slot_count), .ptr(wr_ptr)
    );

    fbseq_ring_ptr #(.SLOT_W(SLOT_W)) u_rd_ptr (
        .clk(clk), .rst_n(rst_n), .clr(clr_req), .adv(serve || overwrite),
        .slot_count(slot_count), .ptr(rd_ptr)
    );

    fbseq_pend_ctr #(.CW(CW)) u_pend (
        .clk(clk), .rst_n(rst_n), .clr(clr_req), .inc(pend_inc),
        .dec(serve), .avail(avail)
    );

    fbseq_phase_ctl #(.POST_W(POST_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(clr_req), .circ(circ_mode),
        .trig(trig), .frame_tick(accept), .post_count(post_count),
        .phase(phase)
    );

    // Track the number of stored frames.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_req) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + CW'(accept && !overwrite) - CW'(serve);
        end
    end

    // Register the write and read commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_q    <= 1'b0;
            wr_slot_q  <= '0;
            rd_start_q <= 1'b0;
            rd_slot_q  <= '0;
        end else begin
            wr_en_q    <= accept;
            wr_slot_q  <= wr_ptr;
            rd_start_q <= serve;
            rd_slot_q  <= rd_ptr;
        end
    end

    assign wr_en    = wr_en_q;
    assign wr_slot  = wr_slot_q;
    assign rd_start = rd_start_q;
    assign rd_slot  = rd_slot_q;
    assign empty    = is_empty;
    assign full     = is_full;
    assign stopped  = (phase == PH_STOP);

    // R3: a queue-mode frame offered while full is not written.
    a_r3_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!circ_mode && full && frame_in && !clr_req) |=> !wr_en);
    // R6: a clear leaves no command and an empty buffer.
    a_r6_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (!wr_en && !rd_start && empty && !stopped));
    // R7: no read starts in ring mode before recording has stopped.
    a_r7_no_read_while_recording: assert property (@(posedge clk) disable iff (!rst_n)
        (circ_mode && !stopped) |=> !rd_start);
    // R8: once stopped, no frame is written.
    a_r8_stopped_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !clr_req) |=> !wr_en);
    // R12: occupancy never passes the slot count.
    a_r12_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q <= slot_count));
endmodule

// File: tb/sim_fbuf_seq_mgr.sv
// Scoreboard bench: the driver queues expected write and read slots,
// a monitor compares them against the commands the design issues.
module sim_fbuf_seq_mgr;
    localparam int SLOT_W = 3;
    localparam int POST_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              circ_mode = 1'b0;
    logic [SLOT_W:0]   slot_count = 4'd4;
    logic [POST_W-1:0] post_count = '0;
    logic              frame_in = 1'b0;
    logic              rd_req = 1'b0;
    logic              clr_req = 1'b0;
    logic              wr_en, rd_start, empty, full, stopped;
    logic [SLOT_W-1:0] wr_slot, rd_slot;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    wr_q[$];
    string wr_tag[$];
    int    rd_q[$];
    string rd_tag[$];

    always #2 clk = ~clk;

    fbuf_seq_mgr #(.SLOT_W(SLOT_W), .POST_W(POST_W)) u0 (
        .clk(clk), .rst_n(rst_n), .circ_mode(circ_mode),
        .slot_count(slot_count), .post_count(post_count),
        .frame_in(frame_in), .rd_req(rd_req), .clr_req(clr_req),
        .wr_en(wr_en), .wr_slot(wr_slot), .rd_start(rd_start),
        .rd_slot(rd_slot), .empty(empty), .full(full), .stopped(stopped)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic exp_wr(input int slot, input string tag);
        wr_q.push_back(slot);
        wr_tag.push_back(tag);
    endtask

    task automatic exp_rd(input int slot, input string tag);
        rd_q.push_back(slot);
        rd_tag.push_back(tag);
    endtask

    // Called just after a falling edge: drive for one rising edge.
    task automatic step(input bit f, input bit r, input bit c);
        frame_in = f;
        rd_req   = r;
        clr_req  = c;
        @(posedge clk);
        @(negedge clk);
        frame_in = 1'b0;
        rd_req   = 1'b0;
        clr_req  = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic flags(input bit e, input bit f, input bit s, input string tag);
        check(empty == e, {tag, " empty"}, int'(empty), int'(e));
        check(full == f, {tag, " full"}, int'(full), int'(f));
        check(stopped == s, {tag, " stopped"}, int'(stopped), int'(s));
    endtask

    task automatic drained(input string tag);
        check(wr_q.size() == 0, {tag, " missing writes"}, wr_q.size(), 0);
        check(rd_q.size() == 0, {tag, " missing reads"}, rd_q.size(), 0);
        wr_q.delete(); wr_tag.delete(); rd_q.delete(); rd_tag.delete();
    endtask

    // Monitor: compare each issued command with the front of its queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (wr_q.size() == 0) begin
                    check(1'b0, "R3/R6/R8 unexpected wr_en", int'(wr_slot), -1);
                end else begin
                    check(int'(wr_slot) == wr_q[0], wr_tag[0], int'(wr_slot), wr_q[0]);
                    void'(wr_q.pop_front()); void'(wr_tag.pop_front());
                end
            end
            if (rd_start) begin
                if (rd_q.size() == 0) begin
                    check(1'b0, "R7/R11 unexpected rd_start", int'(rd_slot), -1);
                end else begin
                    check(int'(rd_slot) == rd_q[0], rd_tag[0], int'(rd_slot), rd_q[0]);
                    void'(rd_q.pop_front()); void'(rd_tag.pop_front());
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        idle(3);
        flags(1'b1, 1'b0, 1'b0, "R1 in reset");
        check(!wr_en && !rd_start, "R1 strobes in reset", int'(wr_en | rd_start), 0);
        rst_n = 1'b1;
        idle(1);
        flags(1'b1, 1'b0, 1'b0, "R1 after reset");

        // Queue mode: write order, wrap, full, drop, read order.
        exp_wr(0, "R2 wr0"); step(1, 0, 0);
        exp_wr(1, "R2 wr1"); step(1, 0, 0);
        exp_wr(2, "R2 wr2"); step(1, 0, 0);
        exp_rd(0, "R4 rd oldest"); step(0, 1, 0);
        exp_wr(3, "R2 wr3"); step(1, 0, 0);
        exp_wr(0, "R2 wrap"); step(1, 0, 0);
        flags(1'b0, 1'b1, 1'b0, "R12 full at slot_count");
        step(1, 0, 0);                                   // R3 dropped
        flags(1'b0, 1'b1, 1'b0, "R3 still full");
        exp_rd(1, "R4 rd1"); step(0, 1, 0);
        exp_rd(2, "R4 rd2"); step(0, 1, 0);
        exp_rd(3, "R4 rd3"); step(0, 1, 0);
        exp_rd(0, "R4 rd wrapped, R3 drop left order"); step(0, 1, 0);
        step(0, 1, 0);                                   // early request 1
        step(0, 1, 0);                                   // early request 2
        idle(2);
        flags(1'b1, 1'b0, 1'b0, "R5 held while empty");
        exp_wr(1, "R5 wr"); exp_rd(1, "R5 immediate rd"); step(1, 0, 0);
        exp_wr(2, "R5 wr"); exp_rd(2, "R5 immediate rd"); step(1, 0, 0);
        exp_wr(3, "R5 stored"); step(1, 0, 0);
        idle(2);
        flags(1'b0, 1'b0, 1'b0, "R12 one stored");
        drained("R4/R5");

        // Clear wins over a frame and a request in the same cycle.
        step(1, 1, 1);
        idle(2);
        flags(1'b1, 1'b0, 1'b0, "R6 after clear");
        exp_wr(0, "R6 pointer reset"); step(1, 0, 0);
        idle(2);
        drained("R6");
        step(0, 0, 1);

        // Pending-request saturation: 20 requests, only 15 count.
        for (int i = 0; i < 20; i++) step(0, 1, 0);
        for (int i = 0; i < 20; i++) begin
            if (i < 15) begin
                exp_wr(i % 4, "R11 served wr");
                exp_rd(i % 4, "R11 served rd");
            end else if (i < 19) begin
                exp_wr(i % 4, "R11 stored after saturation");
            end
            step(1, 0, 0);
        end
        idle(2);
        flags(1'b0, 1'b1, 1'b0, "R11 full after 15 served");
        drained("R11");
        step(0, 0, 1);

        // Ring mode, post_count = 2.
        circ_mode  = 1'b1;
        post_count = 8'd2;
        step(0, 0, 1);
        for (int i = 0; i < 6; i++) begin
            exp_wr(i % 4, "R7 ring write");
            step(1, 0, 0);
        end
        flags(1'b0, 1'b1, 1'b0, "R7 full while overwriting");
        step(0, 1, 0);                                   // trigger
        step(0, 1, 0);                                   // early request
        step(0, 1, 0);                                   // early request
        idle(2);
        flags(1'b0, 1'b1, 1'b0, "R8 trigger not a read");
        exp_wr(2, "R8 post frame 1");
        step(1, 0, 0);
        exp_wr(3, "R8 post frame 2");
        exp_rd(0, "R9 early req oldest");
        exp_rd(1, "R9 early req next");
        step(1, 0, 0);
        idle(3);
        flags(1'b0, 1'b0, 1'b1, "R8 stopped after post frames");
        step(1, 0, 0);                                   // ignored
        idle(1);
        exp_rd(2, "R9 req after stop"); step(0, 1, 0);
        exp_rd(3, "R9 req after stop"); step(0, 1, 0);
        step(0, 1, 0);                                   // nothing left
        step(1, 0, 0);                                   // ignored
        idle(2);
        flags(1'b1, 1'b0, 1'b1, "R10 still stopped");
        drained("R8/R9/R10");
        step(0, 0, 1);
        idle(1);
        flags(1'b1, 1'b0, 1'b0, "R10 clear re-arms");

        // Ring mode, post_count = 0: stop at once.
        post_count = 8'd0;
        exp_wr(0, "R7 wr0"); step(1, 0, 0);
        exp_wr(1, "R7 wr1"); step(1, 0, 0);
        step(0, 1, 0);                                   // trigger
        idle(1);
        flags(1'b0, 1'b0, 1'b1, "R8 zero post stops");
        step(1, 0, 0);                                   // ignored
        exp_rd(0, "R9 rd0"); step(0, 1, 0);
        exp_rd(1, "R9 rd1"); step(0, 1, 0);
        idle(2);
        flags(1'b1, 1'b0, 1'b1, "R12 empty after reads");
        drained("R8 zero");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule